// File: doc/BRIEF.md
# Two-Wire Configuration Register Access Slave

This block is the serial slave that sits between a two-wire management bus and the configuration storage of a supervisor device. A host reaches two register windows through it. One is a volatile configuration window. The other is a mirror of the non-volatile configuration region. The host selects a register by sending a command byte that loads an internal pointer. It then writes one data byte to that register, or it reads the register back. A read can start straight from the current pointer. It can also follow a write phase through a repeated START. Accesses that are not allowed are refused with a NACK.

Both bus lines are oversampled by the system clock. Each passes through a synchronizer, and START and STOP are found as edges of SDA while SCL is high. The slave only pulls SDA low; it never drives it high. The device answers one 7-bit address. The upper five bits of that address are a parameter, and the lower two come from strap pins, so four devices can share one bus. Register storage lives outside the block. The block reaches it through a plain port that carries the pointer, a one-cycle write strobe with its data, and a one-cycle read strobe with read data that arrives combinationally. A busy input stands for a reboot or a non-volatile write in progress.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, the SDA pull-down is released, the pointer selects the volatile window at index 00h, and neither the write strobe nor the read strobe is active.
- R2: The first byte after a START holds the 7-bit address in bits 7:1. That address is {DEV_ID, strap_i}, with default DEV_ID 10100b. The slave pulls SDA low for the ninth clock only when the address matches. When it does not match, the slave pulls nothing and ignores the bus until the next START.
- R3: While busy_i is high during the address byte, the slave NACKs its own address, for reads and for writes alike.
- R4: The command byte is the second byte of a write. Bit 7 selects the window (0 volatile, 1 non-volatile mirror) and bits 6:0 give the index. The command is legal only when the index is at most 45h. A legal command is ACKed and loads the pointer. An illegal command is NACKed and leaves the pointer unchanged.
- R5: A send-byte (address with write, command byte, STOP) only moves the pointer and raises no write strobe.
- R6: The data byte that follows a legal command is ACKed. It causes exactly one single-cycle write strobe, carrying that byte and the current pointer.
- R7: A second data byte in the same write transaction is NACKed and produces no write strobe.
- R8: An address byte with bit 0 set starts a read. The slave sends the register at the pointer, MSB first, and raises one read strobe for each byte it sends. It never raises a read strobe and a write strobe together.
- R9: A write of the address and command, followed by a repeated START and a read address, returns the register that the new command selected.
- R10: When the master ACKs a read byte, the slave sends the same register again. When the master NACKs it, the slave releases SDA and goes back to idle.
- R11: The SDA pull-down changes only while the synchronized SCL is low.
- R12: After a STOP, or after a byte the slave has NACKed, the slave releases SDA and ignores all bus activity until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| strap_i | input | 2 | Low two bits of the slave address |
| busy_i | input | 1 | Reboot or non-volatile write in progress |
| rf_nv_o | output | 1 | Pointer window: 1 = non-volatile mirror |
| rf_idx_o | output | 7 | Pointer index inside the window |
| rf_wr_en_o | output | 1 | One-cycle write strobe |
| rf_wr_data_o | output | 8 | Data for the write strobe |
| rf_rd_en_o | output | 1 | One-cycle strobe when a read byte is captured |
| rf_rd_data_i | input | 8 | Register contents at the pointer, combinational |

## Verification
The bench drives the edges of both windows. Index 45h in the mirror must be accepted, while 46h and C6h must be refused. A bound check that is off by one would ACK 46h or NACK 45h, and the pointer seen at the port would then move when it should not. Several cases test what happens after a refusal or a STOP. These are a wrong strap address, a busy device, an illegal command, and a second data byte. In each case the bench then sends bytes without a fresh START, so a slave that keeps decoding would ACK them or raise a write strobe. A repeated START between the command and a read, and a read where the master ACKs, show whether the pointer and the re-read path behave. A slave that gets them wrong returns stale data or holds SDA low past the final byte.

// File: rtl/smb_cfg_pkg.sv
// Shared types and derived widths for the two-wire configuration slave.
// Assumes a 7-bit bus address split into a fixed part and strap bits.
package smb_cfg_pkg;
    localparam int ADDR_W   = 7;
    localparam int STRAP_W  = 2;
    localparam int DEVID_W  = ADDR_W - STRAP_W;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = BYTE_W - 1;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } smb_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_DATA,
        PH_EXTRA
    } smb_phase_e;
endpackage

// File: rtl/smb_line_sync.sv
// Synchronizes SCL and SDA into the clock domain and finds bus events.
// Assumes both lines idle high; the reset value of every stage is 1.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0]             line_in;
    logic [LINES-1:0][STAGES-1:0] pipe;
    logic                         scl_prev;
    logic                         sda_prev;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Shift one bus line through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '1;
            else        pipe[g] <= {pipe[g][STAGES-2:0], line_in[g]};
        end
    end

    assign scl_q = pipe[0][STAGES-1];
    assign sda_q = pipe[1][STAGES-1];

    // Keep the previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_q;
            sda_prev <= sda_q;
        end
    end

    assign scl_rise  = scl_q & ~scl_prev;
    assign scl_fall  = ~scl_q & scl_prev;
    assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/smb_decode.sv
// Decodes a received byte both as a slave address and as a command.
// Purely combinational; the FSM decides which result applies.
module smb_decode
    import smb_cfg_pkg::*;
#(
    parameter logic [DEVID_W-1:0] DEV_ID   = 5'b10100,
    parameter logic [IDX_W-1:0]   REG_LAST = 7'h45
) (
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               addr_hit_o,
    output logic               legal_o,
    output logic               nv_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Compare the address field and bound-check the command index.
    always_comb begin
        addr_hit_o = (byte_i[BYTE_W-1:1] == {DEV_ID, strap_i});
        nv_o       = byte_i[BYTE_W-1];
        idx_o      = byte_i[IDX_W-1:0];
        legal_o    = (byte_i[IDX_W-1:0] <= REG_LAST);
    end
endmodule

// File: rtl/smb_cfg_fsm.sv
// Byte-level protocol engine: shifts bits in and out, ACKs or NACKs,
// holds the register pointer and issues register-file strobes.
// Assumes SCL and SDA events come from a synchronizer; SDA is changed
// only on a synchronized SCL fall.
module smb_cfg_fsm
    import smb_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy_i,
    input  logic              addr_hit_i,
    input  logic              legal_i,
    input  logic              cmd_nv_i,
    input  logic [IDX_W-1:0]  cmd_idx_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              sda_oe_o,
    output logic              ptr_nv_o,
    output logic [IDX_W-1:0]  ptr_idx_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_en_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    smb_state_e        state;
    smb_phase_e        phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              go_tx;
    logic              mack;

    assign byte_o = shreg;

    // Main protocol sequencer; START and STOP take priority over all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_ADDR;
            bitcnt    <= '0;
            shreg     <= '0;
            go_tx     <= 1'b0;
            mack      <= 1'b0;
            sda_oe_o  <= 1'b0;
            ptr_nv_o  <= 1'b0;
            ptr_idx_o <= '0;
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
            rd_en_o   <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            rd_en_o <= 1'b0;
            if (start_det) begin
                state    <= ST_RX;
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        sda_oe_o <= 1'b0;
                    end
                    ST_RX: begin
                        if (scl_rise && bitcnt < FULL) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_q};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == FULL) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (addr_hit_i && !busy_i) begin
                                        sda_oe_o <= 1'b1;
                                        state    <= ST_ACK;
                                        go_tx    <= shreg[0];
                                        phase    <= PH_CMD;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_CMD: begin
                                    if (legal_i) begin
                                        ptr_nv_o  <= cmd_nv_i;
                                        ptr_idx_o <= cmd_idx_i;
                                        sda_oe_o  <= 1'b1;
                                        state     <= ST_ACK;
                                        go_tx     <= 1'b0;
                                        phase     <= PH_DATA;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_DATA: begin
                                    wr_en_o   <= 1'b1;
                                    wr_data_o <= shreg;
                                    sda_oe_o  <= 1'b1;
                                    state     <= ST_ACK;
                                    go_tx     <= 1'b0;
                                    phase     <= PH_EXTRA;
                                end
                                default: begin
                                    state <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (go_tx) begin
                                shreg    <= rd_data_i;
                                rd_en_o  <= 1'b1;
                                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                                state    <= ST_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == FULL) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_q;
                        end else if (scl_fall) begin
                            if (mack) begin
                                bitcnt   <= '0;
                                shreg    <= rd_data_i;
                                rd_en_o  <= 1'b1;
                                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        state <= ST_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_cfg_slave.sv
// Top of the two-wire configuration slave: line synchronizer, byte
// decoder and protocol engine. Assumes an external open-drain pad that
// pulls SDA low while sda_oe_o is 1, and a register file that answers
// rf_rd_data_i combinationally for the current pointer.
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [4:0] DEV_ID      = 5'b10100,
    parameter logic [6:0] REG_LAST    = 7'h45,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] strap_i,
    input  logic       busy_i,
    output logic       rf_nv_o,
    output logic [6:0] rf_idx_o,
    output logic       rf_wr_en_o,
    output logic [7:0] rf_wr_data_o,
    output logic       rf_rd_en_o,
    input  logic [7:0] rf_rd_data_i
);
    logic              scl_q;
    logic              sda_q;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic              addr_hit;
    logic              cmd_legal;
    logic              cmd_nv;
    logic [IDX_W-1:0]  cmd_idx;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_q     (scl_q),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_decode #(.DEV_ID(DEV_ID), .REG_LAST(REG_LAST)) u_dec (
        .byte_i     (rx_byte),
        .strap_i    (strap_i),
        .addr_hit_o (addr_hit),
        .legal_o    (cmd_legal),
        .nv_o       (cmd_nv),
        .idx_o      (cmd_idx)
    );

    smb_cfg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_q      (sda_q),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .busy_i     (busy_i),
        .addr_hit_i (addr_hit),
        .legal_i    (cmd_legal),
        .cmd_nv_i   (cmd_nv),
        .cmd_idx_i  (cmd_idx),
        .rd_data_i  (rf_rd_data_i),
        .byte_o     (rx_byte),
        .sda_oe_o   (sda_oe_o),
        .ptr_nv_o   (rf_nv_o),
        .ptr_idx_o  (rf_idx_o),
        .wr_en_o    (rf_wr_en_o),
        .wr_data_o  (rf_wr_data_o),
        .rd_en_o    (rf_rd_en_o)
    );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
// Property checker for the two-wire configuration slave, bound to the top.
module smb_cfg_slave_chk #(
    parameter logic [6:0] REG_LAST = 7'h45
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe_o,
    input logic       scl_q,
    input logic       stop_det,
    input logic       rf_wr_en_o,
    input logic       rf_rd_en_o,
    input logic [6:0] rf_idx_o
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_q)); // R11

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |=> !rf_wr_en_o); // R6

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en_o && rf_rd_en_o)); // R8

    AST_PTR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rf_idx_o <= REG_LAST); // R4

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o); // R12
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.REG_LAST(REG_LAST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe_o   (sda_oe_o),
    .scl_q      (scl_q),
    .stop_det   (stop_det),
    .rf_wr_en_o (rf_wr_en_o),
    .rf_rd_en_o (rf_rd_en_o),
    .rf_idx_o   (rf_idx_o)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
    localparam int Q = 20;
    localparam int WDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [1:0] strap = 2'b01;
    logic       busy = 1'b0;
    logic       rf_nv;
    logic [6:0] rf_idx;
    logic       rf_wr_en;
    logic [7:0] rf_wr_data;
    logic       rf_rd_en;
    logic [7:0] rf_rd_data;
    logic       sda_line;

    logic [7:0] vol [128];
    logic [7:0] nvm [128];

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int oe_hi_chg = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_line   = m_sda & ~sda_oe;
    assign rf_rd_data = rf_nv ? nvm[rf_idx] : vol[rf_idx];

    smb_cfg_slave u_smb_cfg_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .strap_i      (strap),
        .busy_i       (busy),
        .rf_nv_o      (rf_nv),
        .rf_idx_o     (rf_idx),
        .rf_wr_en_o   (rf_wr_en),
        .rf_wr_data_o (rf_wr_data),
        .rf_rd_en_o   (rf_rd_en),
        .rf_rd_data_i (rf_rd_data)
    );

    // Register-file model and strobe / SDA-timing monitors.
    always @(negedge clk) begin
        if (rf_wr_en) begin
            wr_cnt++;
            if (rf_nv) nvm[rf_idx] = rf_wr_data;
            else       vol[rf_idx] = rf_wr_data;
        end
        if (rf_rd_en) rd_cnt++;
        if (sda_oe !== oe_prev && m_scl) oe_hi_chg++;
        oe_prev = sda_oe;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic read_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic wbyte(logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        read_bit(b);
        ack = ~b;
    endtask

    task automatic rbyte(logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic t_reset();
        check("R1 sda_oe", sda_oe, 0);
        check("R1 rf_nv", rf_nv, 0);
        check("R1 rf_idx", rf_idx, 0);
        check("R1 strobes", {rf_wr_en, rf_rd_en}, 0);
    endtask

    task automatic t_write_vol();
        logic a; int w0 = wr_cnt;
        bus_start();
        wbyte(8'hA2, a); check("R2 addr ack", a, 1);
        wbyte(8'h12, a); check("R4 cmd ack", a, 1);
        wbyte(8'hA5, a); check("R6 data ack", a, 1);
        bus_stop();
        check("R6 one write", wr_cnt - w0, 1);
        check("R6 written value", vol[8'h12], 8'hA5);
        check("R4 pointer", {rf_nv, rf_idx}, 8'h12);
    endtask

    task automatic t_write_nv_edge();
        logic a;
        bus_start();
        wbyte(8'hA2, a);
        wbyte(8'hC5, a); check("R4 last mirror idx ack", a, 1);
        wbyte(8'h3C, a); check("R6 mirror data ack", a, 1);
        bus_stop();
        check("R6 mirror value", nvm[7'h45], 8'h3C);
        check("R4 mirror pointer", {rf_nv, rf_idx}, 8'hC5);
    endtask

    task automatic t_illegal();
        logic a; int w0 = wr_cnt;
        bus_start();
        wbyte(8'hA2, a);
        wbyte(8'h46, a); check("R4 46h nack", a, 0);
        wbyte(8'h77, a); check("R12 ignored after nack", a, 0);
        bus_stop();
        check("R4 pointer kept", {rf_nv, rf_idx}, 8'hC5);
        check("R12 no write", wr_cnt - w0, 0);
        bus_start();
        wbyte(8'hA2, a);
        wbyte(8'hC6, a); check("R4 C6h nack", a, 0);
        bus_stop();
        check("R4 pointer kept 2", {rf_nv, rf_idx}, 8'hC5);
    endtask

    task automatic t_send_byte();
        logic a; int w0 = wr_cnt;
        bus_start();
        wbyte(8'hA2, a);
        wbyte(8'h05, a); check("R5 cmd ack", a, 1);
        bus_stop();
        check("R5 pointer", {rf_nv, rf_idx}, 8'h05);
        check("R5 no write", wr_cnt - w0, 0);
    endtask

    task automatic t_receive();
        logic a; logic [7:0] d; int r0 = rd_cnt;
        bus_start();
        wbyte(8'hA3, a); check("R8 read addr ack", a, 1);
        rbyte(1'b0, d); check("R8 read data", d, 8'h96);
        check("R10 released after nack", sda_oe, 0);
        bus_stop();
        check("R8 one read strobe", rd_cnt - r0, 1);
    endtask

    task automatic t_byte_read();
        logic a; logic [7:0] d;
        bus_start();
        wbyte(8'hA2, a);
        wbyte(8'h12, a);
        bus_rstart();
        wbyte(8'hA3, a); check("R9 read addr ack", a, 1);
        rbyte(1'b0, d); check("R9 read data", d, 8'hA5);
        bus_stop();
    endtask

    task automatic t_multi_read();
        logic a; logic [7:0] d; int r0 = rd_cnt;
        bus_start();
        wbyte(8'hA3, a);
        rbyte(1'b1, d); check("R10 first byte", d, 8'hA5);
        rbyte(1'b0, d); check("R10 repeat byte", d, 8'hA5);
        check("R10 released", sda_oe, 0);
        bus_stop();
        check("R10 two strobes", rd_cnt - r0, 2);
    endtask

    task automatic t_wrong_addr();
        logic a; int w0 = wr_cnt;
        bus_start();
        wbyte(8'hA6, a); check("R2 mismatch nack", a, 0);
        wbyte(8'h05, a); check("R2 ignored byte", a, 0);
        wbyte(8'h99, a); check("R2 ignored data", a, 0);
        bus_stop();
        check("R2 pointer kept", {rf_nv, rf_idx}, 8'h12);
        check("R2 no write", wr_cnt - w0, 0);
    endtask

    task automatic t_busy();
        logic a; logic [7:0] d;
        busy = 1'b1;
        bus_start(); wbyte(8'hA2, a); check("R3 busy write nack", a, 0); bus_stop();
        bus_start(); wbyte(8'hA3, a); check("R3 busy read nack", a, 0); bus_stop();
        busy = 1'b0;
        bus_start(); wbyte(8'hA3, a); check("R3 ack when free", a, 1);
        rbyte(1'b0, d); bus_stop();
    endtask

    task automatic t_second_data();
        logic a; int w0 = wr_cnt;
        bus_start();
        wbyte(8'hA2, a);
        wbyte(8'h20, a);
        wbyte(8'h11, a); check("R6 first data ack", a, 1);
        wbyte(8'h22, a); check("R7 second data nack", a, 0);
        bus_stop();
        check("R7 one write", wr_cnt - w0, 1);
        check("R7 value kept", vol[8'h20], 8'h11);
    endtask

    task automatic t_stop_mid();
        logic a; logic [7:0] d;
        bus_start();
        wbyte(8'hA2, a);
        bus_stop();
        check("R12 released after stop", sda_oe, 0);
        m_scl = 1'b0; wq();
        wbyte(8'hA2, a); check("R12 no start no ack", a, 0);
        m_scl = 1'b1; wq();
        bus_start();
        wbyte(8'hA3, a);
        rbyte(1'b0, d); check("R12 recovers", d, 8'h11);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            vol[i] = 8'h00;
            nvm[i] = 8'h00;
        end
        vol[5] = 8'h96;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        wq();
        t_write_vol();
        t_write_nv_edge();
        t_illegal();
        t_send_byte();
        t_receive();
        t_byte_read();
        t_multi_read();
        t_wrong_addr();
        t_busy();
        t_second_data();
        t_stop_mid();
        check("R11 no SDA change with SCL high", oe_hi_chg, 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule